// File: doc/BRIEF.md
# USB Packet Receive Checker

This block takes sampled two-wire differential line states from a USB line receiver and turns them into checked packets. Each bit cell arrives as a pair of line levels together with a strobe. The block decodes the NRZI line coding and removes stuffed zeros. It finds the start of a packet after the SYNC field and its end at the end-of-packet signal. It checks the packet ID and, where the packet type calls for one, its CRC.

The received bytes are passed on as a stream with valid and last flags. Each packet then ends in exactly one outcome pulse: a packet-good strobe carrying the PID, or one error flag. A well-formed data packet also raises a request to start a handshake reply. A faulty packet raises no request and is dropped quietly, so the host notices only when its response timer expires and it sends the packet again.

The line receiver and the recovery of bit timing are outside this block. It expects one bit cell per cycle in which `bit_en` is high.

Top module: `usb_rx_checker`

## Requirements
- R1: In a cycle with `bit_en` high, the line state is {`line_dp`,`line_dm`}: 10 = J, 01 = K, 00 = SE0, 11 = SE1. A J or K equal to the previous J/K state decodes as 1, and a change decodes as 0. The idle line is J.
- R2: A packet starts after the decoded bits 0,0,0,0,0,0,0,1, which is KJKJKJKK sent from an idle J line. The next kept bit is bit 0 of the PID byte. Any other preamble starts nothing.
- R3: Inside a packet, the decoded 0 that follows six consecutive 1s is removed from the data. The closing 1 of SYNC counts toward that run.
- R4: A 1 where a stuffed 0 is due is a stuffing violation. The packet then ends with `err_stuff` and raises neither `pkt_good` nor `hs_req`.
- R5: The PID byte is valid only if bits 7:4 are the bitwise complement of bits 3:0. Otherwise the packet ends with `err_form`.
- R6: PID bits 1:0 select the check. 01 applies CRC5 (x^5+x^2+1, register preset to ones, residual 01100). 11 applies CRC16 (x^16+x^15+x^2+1, preset to ones, residual 0x800D). 10 and 00 apply no CRC. Both CRCs run over the bits that follow the PID. A mismatch ends the packet with `err_crc`.
- R7: A packet with no bits, or whose unstuffed length is not a whole number of bytes, ends with `err_form`.
- R8: A packet ends on SE0, SE0, J. If anything else follows the first SE0, `err_form` is raised at that symbol and the block returns to searching for SYNC.
- R9: Bytes are sent out LSB-first on `rx_data` as one-cycle `rx_valid` pulses. A byte is released when the byte after it completes. The final byte is released at packet end with `rx_last` set.
- R10: `pkt_good` and `pkt_pid` appear one cycle after the edge that samples the closing J of a packet. `hs_req` pulses with them only when PID bits 1:0 are 11.
- R11: Every packet that reaches its closing J gives exactly one outcome pulse. The priority is `err_stuff`, then `err_form`, then `err_crc`, and `pkt_good` only when none of these applies.
- R12: Cycles with `bit_en` low change nothing, whatever the line inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Marks a cycle that carries one bit cell |
| line_dp | input | 1 | Sampled positive line level |
| line_dm | input | 1 | Sampled negative line level |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_last | output | 1 | Marks the final byte of a packet |
| pkt_good | output | 1 | One-cycle strobe: packet well formed |
| pkt_pid | output | 4 | PID of the last good packet |
| hs_req | output | 1 | One-cycle request to send a handshake reply |
| err_stuff | output | 1 | One-cycle strobe: stuffing violation |
| err_form | output | 1 | One-cycle strobe: malformed packet or bad end |
| err_crc | output | 1 | One-cycle strobe: CRC mismatch |

## Verification
Every result is registered in the cycle that takes in the symbol completing it. A byte, an outcome pulse or an abort is therefore visible one cycle after the edge that samples its last bit cell or end symbol. The bench drives each symbol on a falling edge and records the cycle number of the closing J, or of the symbol that breaks the end sequence. It samples outputs on falling edges and requires the outcome pulse in exactly the following cycle. Idle cycles with random line levels are placed between bit cells, which spreads a packet over time but does not move this one-cycle rule.

// File: rtl/usb_rx_pkg.sv
// Shared types and constants for the USB packet receive checker.
// Assumes full-speed style line levels already sampled once per bit cell.
package usb_rx_pkg;

    // Line state as {dp, dm}
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_K   = 2'b01,
        LS_J   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [1:0] {
        CK_NONE  = 2'd0,
        CK_CRC5  = 2'd1,
        CK_CRC16 = 2'd2
    } chk_t;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_RECV = 2'd1,
        ST_EOP1 = 2'd2,
        ST_EOP2 = 2'd3
    } rx_state_t;

    localparam int          SYNC_W   = 8;
    localparam logic [7:0]  SYNC_PAT = 8'h80;   // seven 0s then a 1, oldest bit in bit 0

    localparam int          CRC5_W   = 5;
    localparam logic [4:0]  CRC5_P   = 5'h05;
    localparam logic [4:0]  CRC5_RES = 5'h0C;
    localparam int          CRC16_W  = 16;
    localparam logic [15:0] CRC16_P  = 16'h8005;
    localparam logic [15:0] CRC16_RES = 16'h800D;

endpackage

// File: rtl/usb_rx_line_dec.sv
// Line decoder: classifies the sampled line, undoes NRZI and tracks the
// run of decoded ones for stuffed-bit removal.
// Assumes one bit cell per cycle with bit_en high; in_pkt is high while
// the owner is inside a packet (after SYNC).
module usb_rx_line_dec
    import usb_rx_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_en,
    input  logic  dp,
    input  logic  dm,
    input  logic  in_pkt,
    output line_t sym,
    output logic  nrzi_bit,
    output logic  bit_take,
    output logic  stuff_viol
);
    localparam int CW = $clog2(STUFF_RUN + 1);

    logic          prev_j;   // last J/K level, 1 = J
    logic [CW-1:0] ones;
    logic          is_data;
    logic          at_run;

    // Classify the symbol and derive the decoded bit and stuffing decisions
    always_comb begin
        sym        = line_t'({dp, dm});
        is_data    = (sym == LS_J) || (sym == LS_K);
        nrzi_bit   = ((sym == LS_J) == prev_j);
        at_run     = (ones == CW'(STUFF_RUN));
        bit_take   = bit_en && is_data && !(in_pkt && at_run);
        stuff_viol = bit_en && is_data && in_pkt && at_run && nrzi_bit;
    end

    // Track previous level and the running count of decoded ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_j <= 1'b1;
            ones   <= '0;
        end else if (bit_en) begin
            if (is_data) begin
                prev_j <= (sym == LS_J);
                if (in_pkt && at_run)
                    ones <= '0;
                else if (nrzi_bit)
                    ones <= at_run ? ones : ones + 1'b1;
                else
                    ones <= '0;
            end else begin
                ones <= '0;
            end
        end
    end

endmodule

// File: rtl/usb_rx_crc_unit.sv
// Serial CRC register with a fixed residual compare.
// Assumes data bits arrive LSB-first and the sender appends the inverted
// CRC MSB-first, so a clean packet leaves RESID in the register.
module usb_rx_crc_unit #(
    parameter int           W     = 5,
    parameter logic [W-1:0] POLY  = 5'h05,
    parameter logic [W-1:0] RESID = 5'h0C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic din,
    output logic match
);
    logic [W-1:0] crc;
    logic         fb;

    // Feedback bit and residual compare
    always_comb begin
        fb    = din ^ crc[W-1];
        match = (crc == RESID);
    end

    // Preset on clear, shift one bit per enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            crc <= '1;
        else if (en)
            crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

endmodule

// File: rtl/usb_rx_checker.sv
// USB packet receive checker top: finds SYNC, assembles bytes, checks the
// PID and CRC, detects end of packet and issues one outcome pulse.
// Assumes bit_en marks one bit cell; all outputs are registered pulses
// except pkt_pid, which holds the PID of the last good packet.
module usb_rx_checker
    import usb_rx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int STUFF_RUN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              line_dp,
    input  logic              line_dm,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_last,
    output logic              pkt_good,
    output logic [3:0]        pkt_pid,
    output logic              hs_req,
    output logic              err_stuff,
    output logic              err_form,
    output logic              err_crc
);
    localparam int NIB   = BYTE_W / 2;
    localparam int CNT_W = $clog2(BYTE_W);

    rx_state_t          state;
    logic [SYNC_W-1:0]  sync_sr;
    logic [BYTE_W-1:0]  shreg;
    logic [CNT_W-1:0]   bitcnt;
    logic               have_pid;
    logic               pid_ok;
    logic [3:0]         pid_r;
    chk_t               kind;
    logic [BYTE_W-1:0]  held;
    logic               held_vld;
    logic               stuff_bad;

    line_t              sym;
    logic               nrzi_bit;
    logic               bit_take;
    logic               stuff_viol;
    logic               in_pkt;
    logic               m5;
    logic               m16;

    logic [SYNC_W-1:0]  sync_next;
    logic [BYTE_W-1:0]  byte_new;
    logic               data_take;
    logic               crc_en;
    logic               crc_clr;
    logic               crc_ok;
    logic               do_abort;
    logic               do_final;
    chk_t               kind_new;

    assign in_pkt = (state != ST_HUNT);

    usb_rx_line_dec #(.STUFF_RUN(STUFF_RUN)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .dp         (line_dp),
        .dm         (line_dm),
        .in_pkt     (in_pkt),
        .sym        (sym),
        .nrzi_bit   (nrzi_bit),
        .bit_take   (bit_take),
        .stuff_viol (stuff_viol)
    );

    usb_rx_crc_unit #(.W(CRC5_W), .POLY(CRC5_P), .RESID(CRC5_RES)) u_crc5 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (nrzi_bit),
        .match (m5)
    );

    usb_rx_crc_unit #(.W(CRC16_W), .POLY(CRC16_P), .RESID(CRC16_RES)) u_crc16 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (nrzi_bit),
        .match (m16)
    );

    // Next-state helpers: shift values, PID class, end and abort conditions
    always_comb begin
        sync_next = {nrzi_bit, sync_sr[SYNC_W-1:1]};
        byte_new  = {nrzi_bit, shreg[BYTE_W-1:1]};
        data_take = bit_take && (state == ST_RECV) && !stuff_bad && (sym != LS_SE1);
        crc_en    = data_take && have_pid;
        crc_clr   = (state == ST_HUNT);
        case (byte_new[1:0])
            2'b01:   kind_new = CK_CRC5;
            2'b11:   kind_new = CK_CRC16;
            default: kind_new = CK_NONE;
        endcase
        case (kind)
            CK_CRC5:  crc_ok = m5;
            CK_CRC16: crc_ok = m16;
            default:  crc_ok = 1'b1;
        endcase
        do_abort = bit_en && (((state == ST_RECV) && (sym == LS_SE1)) ||
                              ((state == ST_EOP1) && (sym != LS_SE0)) ||
                              ((state == ST_EOP2) && (sym != LS_J)));
        do_final = bit_en && (state == ST_EOP2) && (sym == LS_J);
    end

    // Packet state machine, byte assembly and outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            sync_sr   <= '1;
            shreg     <= '0;
            bitcnt    <= '0;
            have_pid  <= 1'b0;
            pid_ok    <= 1'b0;
            pid_r     <= '0;
            kind      <= CK_NONE;
            held      <= '0;
            held_vld  <= 1'b0;
            stuff_bad <= 1'b0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            rx_last   <= 1'b0;
            pkt_good  <= 1'b0;
            pkt_pid   <= '0;
            hs_req    <= 1'b0;
            err_stuff <= 1'b0;
            err_form  <= 1'b0;
            err_crc   <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            rx_last   <= 1'b0;
            pkt_good  <= 1'b0;
            hs_req    <= 1'b0;
            err_stuff <= 1'b0;
            err_form  <= 1'b0;
            err_crc   <= 1'b0;

            if (do_abort || do_final) begin
                state    <= ST_HUNT;
                sync_sr  <= '1;
                held_vld <= 1'b0;
                if (held_vld) begin
                    rx_data  <= held;
                    rx_valid <= 1'b1;
                    rx_last  <= 1'b1;
                end
                if (do_abort)
                    err_form <= 1'b1;
                else if (stuff_bad)
                    err_stuff <= 1'b1;
                else if (!have_pid || (bitcnt != '0) || !pid_ok)
                    err_form <= 1'b1;
                else if (!crc_ok)
                    err_crc <= 1'b1;
                else begin
                    pkt_good <= 1'b1;
                    pkt_pid  <= pid_r;
                    hs_req   <= (kind == CK_CRC16);
                end
            end else if (bit_en) begin
                case (state)
                    ST_HUNT: begin
                        if (bit_take) begin
                            if (sync_next == SYNC_PAT) begin
                                state     <= ST_RECV;
                                sync_sr   <= '1;
                                bitcnt    <= '0;
                                have_pid  <= 1'b0;
                                pid_ok    <= 1'b0;
                                kind      <= CK_NONE;
                                held_vld  <= 1'b0;
                                stuff_bad <= 1'b0;
                            end else begin
                                sync_sr <= sync_next;
                            end
                        end else begin
                            sync_sr <= '1;
                        end
                    end
                    ST_RECV: begin
                        if (sym == LS_SE0) begin
                            state <= ST_EOP1;
                        end else if (stuff_viol) begin
                            stuff_bad <= 1'b1;
                        end else if (data_take) begin
                            shreg  <= byte_new;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                                if (held_vld) begin
                                    rx_data  <= held;
                                    rx_valid <= 1'b1;
                                end
                                held     <= byte_new;
                                held_vld <= 1'b1;
                                if (!have_pid) begin
                                    have_pid <= 1'b1;
                                    pid_r    <= byte_new[3:0];
                                    pid_ok   <= (byte_new[BYTE_W-1:NIB] == ~byte_new[NIB-1:0]);
                                    kind     <= kind_new;
                                end
                            end
                        end
                    end
                    ST_EOP1: state <= ST_EOP2;   // only SE0 reaches here
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

endmodule

// File: rtl/usb_rx_sva.sv
// Property checker for the USB packet receive checker, bound to its top.
// Assumes the synchronous active-low reset of the bound design.
module usb_rx_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       rx_valid,
    input logic       rx_last,
    input logic       pkt_good,
    input logic [3:0] pkt_pid,
    input logic       hs_req,
    input logic       err_stuff,
    input logic       err_form,
    input logic       err_crc
);

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pkt_good, err_stuff, err_form, err_crc}));

    assert_hs_data_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req |-> (pkt_good && (pkt_pid[1:0] == 2'b11)));

    assert_last_has_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_last |-> rx_valid);

    assert_idle_no_effect_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || pkt_good || err_stuff || err_form || err_crc) |-> $past(bit_en));

    assert_bad_no_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stuff || err_form || err_crc) |-> !hs_req);

    assert_good_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_good |=> !pkt_good);

endmodule

bind usb_rx_checker usb_rx_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .rx_valid  (rx_valid),
    .rx_last   (rx_last),
    .pkt_good  (pkt_good),
    .pkt_pid   (pkt_pid),
    .hs_req    (hs_req),
    .err_stuff (err_stuff),
    .err_form  (err_form),
    .err_crc   (err_crc)
);

// File: tb/sim_usb_rx_checker.sv
// Bench: directed corner packets plus seeded random packets, expected
// outcome computed from the requirements by bench functions.
module sim_usb_rx_checker;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic       dp;
    logic       dm;
    logic [7:0] rx_data;
    logic       rx_valid, rx_last, pkt_good, hs_req;
    logic       err_stuff, err_form, err_crc;
    logic [3:0] pkt_pid;

    usb_rx_checker u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_dp(dp), .line_dm(dm),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
        .pkt_good(pkt_good), .pkt_pid(pkt_pid), .hs_req(hs_req),
        .err_stuff(err_stuff), .err_form(err_form), .err_crc(err_crc)
    );

    always #5 clk = ~clk;

    localparam logic [1:0] SJ = 2'b10, SK = 2'b01, S0 = 2'b00;
    localparam int OK = 0, ES = 1, EF = 2, EC = 3;

    int cyc = 0;
    int tests = 0, fails = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor state
    logic [7:0] got_b[$];
    int got_last_n, got_last_idx, got_good, got_hs, got_es, got_ef, got_ec, ev_cyc;
    logic [3:0] got_pid;

    // packet under construction (decoded, unstuffed)
    bit pb[$];
    int gap_pct = 0;
    int end_cyc;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) got_b.push_back(rx_data);
            if (rx_last) begin got_last_n++; got_last_idx = got_b.size() - 1; end
            if (pkt_good) begin got_good++; got_pid = pkt_pid; end
            if (hs_req) got_hs++;
            if (err_stuff) got_es++;
            if (err_form) got_ef++;
            if (err_crc) got_ec++;
            if (pkt_good || err_stuff || err_form || err_crc) ev_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        got_b.delete();
        got_last_n = 0; got_last_idx = -1; got_good = 0; got_hs = 0;
        got_es = 0; got_ef = 0; got_ec = 0; ev_cyc = -1;
    endtask

    task automatic drive(input logic [1:0] s);
        @(negedge clk);
        bit_en = 1'b1;
        {dp, dm} = s;
        end_cyc = cyc;
        if (gap_pct > 0 && $urandom_range(99) < gap_pct) begin
            repeat ($urandom_range(3, 1)) begin
                @(negedge clk);
                bit_en = 1'b0;
                {dp, dm} = 2'($urandom_range(3));
            end
        end
    endtask

    task automatic push_bits(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) pb.push_back(v[i]);
    endtask

    function automatic logic [15:0] crc_of(input int w, input int from);
        logic [15:0] c, mask, poly;
        bit fb;
        mask = (w == 5) ? 16'h001F : 16'hFFFF;
        poly = (w == 5) ? 16'h0005 : 16'h8005;
        c = mask;
        for (int i = from; i < pb.size(); i++) begin
            fb = pb[i] ^ c[w-1];
            c = (c << 1) & mask;
            if (fb) c = c ^ poly;
        end
        return ~c & mask;
    endfunction

    task automatic add_crc(input int w);
        logic [15:0] c;
        c = crc_of(w, 8);
        for (int k = w - 1; k >= 0; k--) pb.push_back(c[k]);
    endtask

    // Build a packet: kind 0 token, 1 data, 2 handshake
    task automatic build(input logic [3:0] pid, input int kind, input int nbytes,
                         input bit pid_bad, input bit ff_fill);
        logic [3:0] hi;
        pb.delete();
        hi = ~pid;
        if (pid_bad) hi = hi ^ 4'($urandom_range(15, 1));
        push_bits({8'h00, hi, pid}, 8);
        if (kind == 0) begin
            push_bits(16'($urandom_range(2047)), 11);
            add_crc(5);
        end else if (kind == 1) begin
            for (int i = 0; i < nbytes; i++)
                push_bits(ff_fill ? 16'h00FF : 16'($urandom_range(255)), 8);
            add_crc(16);
        end
    endtask

    // Encode: SYNC, stuffing, NRZI; eop_mode 0 normal end, 1 SE0 then K
    task automatic send(input bit no_stuff, input int eop_mode);
        logic lvl;
        int ones;
        drive(SJ); drive(SJ);
        drive(SK); drive(SJ); drive(SK); drive(SJ);
        drive(SK); drive(SJ); drive(SK); drive(SK);
        lvl = 1'b0;
        ones = 1;
        for (int i = 0; i < pb.size(); i++) begin
            if (pb[i]) ones++; else begin ones = 0; lvl = ~lvl; end
            drive(lvl ? SJ : SK);
            if (!no_stuff && ones == 6) begin
                lvl = ~lvl; ones = 0;
                drive(lvl ? SJ : SK);
            end
        end
        if (eop_mode == 0) begin drive(S0); drive(S0); drive(SJ); end
        else begin drive(S0); drive(SK); end
        @(negedge clk); bit_en = 1'b0; {dp, dm} = SJ;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_pkt(input string tag, input bit no_stuff, input int eop_mode,
                           input int exp, input logic [3:0] pid);
        logic [7:0] eb;
        int nb;
        bit same;
        clear_mon();
        send(no_stuff, eop_mode);
        chk((got_good + got_es + got_ef + got_ec) == 1, {tag, " R11 one outcome"},
            got_good + got_es + got_ef + got_ec, 1);
        chk(ev_cyc == end_cyc + 1, {tag, " R10 outcome latency"}, ev_cyc - end_cyc, 1);
        case (exp)
            OK: chk(got_good == 1, {tag, " R10 pkt_good"}, got_good, 1);
            ES: chk(got_es == 1, {tag, " R4 err_stuff"}, got_es, 1);
            EF: chk(got_ef == 1, {tag, " R5 R7 R8 err_form"}, got_ef, 1);
            default: chk(got_ec == 1, {tag, " R6 err_crc"}, got_ec, 1);
        endcase
        chk(got_hs == ((exp == OK && pid[1:0] == 2'b11) ? 1 : 0), {tag, " R10 hs_req"},
            got_hs, (exp == OK && pid[1:0] == 2'b11) ? 1 : 0);
        if (exp == OK) begin
            chk(got_pid == pid, {tag, " R10 pid"}, got_pid, pid);
            nb = pb.size() / 8;
            same = (got_b.size() == nb);
            for (int i = 0; i < nb && same; i++) begin
                eb = '0;
                for (int k = 0; k < 8; k++) eb[k] = pb[i*8 + k];
                if (got_b[i] != eb) same = 0;
            end
            chk(same, {tag, " R1 R3 R9 byte stream"}, got_b.size(), nb);
            chk(got_last_n == 1 && got_last_idx == nb - 1, {tag, " R9 last flag"},
                got_last_idx, nb - 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0] pid;
        int kind, corr, exp, nby;
        bit nst;
        void'($urandom(32'd1234));
        rst_n = 1'b0; bit_en = 1'b0; {dp, dm} = SJ;
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!rx_valid && !pkt_good && !hs_req && !err_stuff && !err_form && !err_crc,
            "R10 reset outputs quiet", 1, 0);

        build(4'h1, 0, 0, 0, 0); run_pkt("token R6 CRC5", 0, 0, OK, 4'h1);
        build(4'h3, 1, 3, 0, 1); run_pkt("data FF R3 stuffing", 0, 0, OK, 4'h3);
        build(4'h2, 2, 0, 0, 0); run_pkt("handshake no hs", 0, 0, OK, 4'h2);
        build(4'hB, 1, 0, 0, 0); run_pkt("data empty payload", 0, 0, OK, 4'hB);
        build(4'h9, 0, 0, 1, 0); run_pkt("R5 pid complement bad", 0, 0, EF, 4'h9);
        build(4'h3, 1, 4, 0, 0); pb[20] = ~pb[20]; run_pkt("R6 crc16 flip", 0, 0, EC, 4'h3);
        build(4'h5, 0, 0, 0, 0); pb[12] = ~pb[12]; run_pkt("R6 crc5 flip", 0, 0, EC, 4'h5);
        build(4'h3, 1, 2, 0, 0); push_bits(16'h5, 3); run_pkt("R7 partial byte", 0, 0, EF, 4'h3);
        pb.delete(); run_pkt("R7 empty packet", 0, 0, EF, 4'h0);
        build(4'h3, 1, 2, 0, 1); run_pkt("R4 stuff violation", 1, 0, ES, 4'h3);
        build(4'h3, 1, 2, 1, 1); run_pkt("R11 stuff over form", 1, 0, ES, 4'h3);
        build(4'h3, 1, 2, 1, 0); pb[30] = ~pb[30]; run_pkt("R11 form over crc", 0, 0, EF, 4'h3);
        build(4'h1, 0, 0, 0, 0); run_pkt("R8 bad end sequence", 0, 1, EF, 4'h1);

        // R2: a short false preamble before the real SYNC
        clear_mon();
        drive(SK); drive(SJ); drive(SK); drive(SJ); drive(SJ); drive(SJ);
        build(4'h9, 0, 0, 0, 0); run_pkt("R2 false preamble", 0, 0, OK, 4'h9);

        // R12: idle cycles with random line levels between bit cells
        gap_pct = 40;
        build(4'h7, 1, 5, 0, 0); run_pkt("R12 gaps data", 0, 0, OK, 4'h7);

        for (int n = 0; n < 60; n++) begin
            gap_pct = (n % 3 == 0) ? 30 : 0;
            kind = $urandom_range(2);
            case (kind)
                0: pid = {2'($urandom_range(3)), 2'b01};
                1: pid = {2'($urandom_range(3)), 2'b11};
                default: pid = {2'($urandom_range(3)), 2'b10};
            endcase
            corr = $urandom_range(9);
            nby = $urandom_range(6);
            nst = 0;
            exp = OK;
            if (corr == 4) begin
                kind = 1; pid = 4'hB; nst = 1; nby = 2;
                build(pid, kind, nby, 0, 1); exp = ES;
            end else begin
                build(pid, kind, nby, corr == 0, 0);
                if (corr == 0) exp = EF;
                else if (corr == 2) begin
                    push_bits(16'($urandom_range(127)), $urandom_range(7, 1)); exp = EF;
                end else if (corr == 1 && kind != 2) begin
                    pb[$urandom_range(pb.size() - 1, 8)] ^= 1'b1; exp = EC;
                end
            end
            run_pkt($sformatf("random %0d", n), nst, 0, exp, pid);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule